// File: doc/BRIEF.md
# Severity-Sorted Error Collector with System Event Pulses

This block gathers error reports from a fixed set of on-chip sources: the memory controller, the system agent, each PCIe root port and the root complex event collector. Each report carries a two-bit severity code. The block files the report into one of three status registers: fatal, non-fatal or correctable. Each register has one bit per source, and each source has its own bit position in all three. Software clears a logged bit by writing 1 to it. A per-source mask, held separately for each severity, stops later reports from being logged.

For each severity the block forms one system-event bit. That bit is high when any logged error of the severity is not masked, unless the event mask for that severity forces it low. The bit rising from 0 to 1 produces a one-cycle pulse on the SMI output, the NMI output, or both. A map register chooses which outputs each severity drives.

Software reaches the registers through a plain word port. A write takes effect at the clock edge that samples it. Read data returns on the cycle after the read, flagged by a valid strobe. Reports are always accepted: there is no back-pressure on the report inputs or on the register port. Each source raises its strobe for one cycle per report.

Top module: `gerr_aggregator`

## Requirements
- R1: After reset, all three status registers, all three error masks, the event mask and the map register read 0, and both pulse outputs are low.
- R2: A report from source i sets bit i of the register chosen by its severity code: 0 selects fatal (address 0), 1 non-fatal (address 1), 2 correctable (address 2). Code 3 logs nothing.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: When a report and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: While bit i of a severity's error mask is 1, reports from source i of that severity leave status bit i at 0. The masks sit at address 3 (fatal), 4 (non-fatal) and 5 (correctable).
- R6: The read-only event status at address 6 holds bit 0 fatal, bit 1 non-fatal and bit 2 correctable. Each bit is the OR of that severity's status bits with their error-mask bits at 0. It is forced to 0 while the matching bit of the event mask at address 7 is 1. Masking a bit that is already logged does not clear its status bit.
- R7: When an event status bit goes from 0 to 1, the outputs selected for that severity pulse high for exactly one cycle, starting the cycle after the event bit changes. In the map at address 8, bit 2s selects SMI and bit 2s+1 selects NMI for severity s (0 fatal, 1 non-fatal, 2 correctable). No pulse is produced while the bit stays high.
- R8: When several severities rise in the same cycle, their selections are ORed, giving one single-cycle pulse per output.
- R9: Read data appears with rd_valid one cycle after reg_rd. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_vld | input | N_SRC | One-cycle report strobe per source |
| err_sev | input | 2*N_SRC | Severity code per source, bits 2i+1:2i for source i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address for read or write |
| reg_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| rd_data | output | DATA_W | Read data |
| smi_pulse | output | 1 | One-cycle SMI event |
| nmi_pulse | output | 1 | One-cycle NMI event |

## Verification
The assertions assume that reg_wr and reg_rd never change inside a clock cycle. They also assume that reset is held for at least two edges, so that the two-cycle history used by the pulse properties starts from cleared state. The bench drives every input at the falling edge and holds it for a whole cycle. It keeps reset low for several cycles. It never raises reg_rd and reg_wr together, which keeps each read tied to one predictable register value.

// File: rtl/gerr_pkg.sv
package gerr_pkg;
  localparam int NUM_SEV = 3;
  localparam int SEV_W   = 2;

  typedef enum logic [SEV_W-1:0] {
    SEV_FATAL    = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_CORR     = 2'd2,
    SEV_NONE     = 2'd3
  } sev_e;

  // Word addresses; status and mask blocks are indexed by severity.
  localparam int ADR_STS_BASE = 0;
  localparam int ADR_MSK_BASE = 3;
  localparam int ADR_EVT_STS  = 6;
  localparam int ADR_EVT_MSK  = 7;
  localparam int ADR_EVT_MAP  = 8;

  // Route bits per severity: bit 0 -> SMI, bit 1 -> NMI.
  typedef struct packed {
    logic nmi;
    logic smi;
  } route_t;
endpackage

// File: rtl/gerr_status_bank.sv
module gerr_status_bank #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] report_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic [N_SRC-1:0] sts_o,
  output logic [N_SRC-1:0] live_o
);
  logic [N_SRC-1:0] sts_q;
  logic [N_SRC-1:0] accept;
  logic [N_SRC-1:0] sts_d;

  // A masked source never enters the log.
  assign accept = report_i & ~mask_i;

  // Clearing is applied first so a same-cycle set dominates.
  always_comb begin
    sts_d = (sts_q & ~clr_i) | accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o  = sts_q;
  // Logged errors that are still unmasked feed the event logic.
  assign live_o = sts_q & ~mask_i;
endmodule

// File: rtl/gerr_regfile.sv
module gerr_regfile
  import gerr_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic                             rd_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_SEV-1:0][N_SRC-1:0]    sts_i,
  input  logic [NUM_SEV-1:0]               evt_sts_i,
  output logic [NUM_SEV-1:0][N_SRC-1:0]    msk_o,
  output logic [NUM_SEV-1:0][N_SRC-1:0]    clr_o,
  output logic [NUM_SEV-1:0]               evt_msk_o,
  output route_t [NUM_SEV-1:0]             map_o,
  output logic                             rd_valid_o,
  output logic [DATA_W-1:0]                rd_data_o
);
  localparam int MAP_W = 2 * NUM_SEV;

  logic [NUM_SEV-1:0][N_SRC-1:0] msk_q;
  logic [NUM_SEV-1:0]            evt_msk_q;
  route_t [NUM_SEV-1:0]          map_q;
  logic [DATA_W-1:0]             rd_mux;
  logic                          rd_vld_q;
  logic [DATA_W-1:0]             rd_data_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  // Write-one-to-clear strobes, one vector per severity.
  always_comb begin
    for (int s = 0; s < NUM_SEV; s++) begin
      clr_o[s] = (wr_i && hit(addr_i, ADR_STS_BASE + s)) ? wdata_i[N_SRC-1:0] : '0;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SEV; g++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          msk_q[g] <= '0;
        else if (wr_i && hit(addr_i, ADR_MSK_BASE + g))
          msk_q[g] <= wdata_i[N_SRC-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_msk_q <= '0;
      map_q     <= '0;
    end else if (wr_i) begin
      if (hit(addr_i, ADR_EVT_MSK)) evt_msk_q <= wdata_i[NUM_SEV-1:0];
      if (hit(addr_i, ADR_EVT_MAP)) map_q     <= wdata_i[MAP_W-1:0];
    end
  end

  // Read multiplexer; unused addresses return zero.
  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NUM_SEV; s++) begin
      if (hit(addr_i, ADR_STS_BASE + s)) rd_mux[N_SRC-1:0] = sts_i[s];
      if (hit(addr_i, ADR_MSK_BASE + s)) rd_mux[N_SRC-1:0] = msk_q[s];
    end
    if (hit(addr_i, ADR_EVT_STS)) rd_mux[NUM_SEV-1:0] = evt_sts_i;
    if (hit(addr_i, ADR_EVT_MSK)) rd_mux[NUM_SEV-1:0] = evt_msk_q;
    if (hit(addr_i, ADR_EVT_MAP)) rd_mux[MAP_W-1:0]   = map_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_vld_q <= rd_i;
      if (rd_i) rd_data_q <= rd_mux;
    end
  end

  assign msk_o      = msk_q;
  assign evt_msk_o  = evt_msk_q;
  assign map_o      = map_q;
  assign rd_valid_o = rd_vld_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/gerr_event_unit.sv
module gerr_event_unit
  import gerr_pkg::*;
#(
  parameter int N_SRC = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SEV-1:0][N_SRC-1:0] live_i,
  input  logic [NUM_SEV-1:0]            evt_msk_i,
  input  route_t [NUM_SEV-1:0]          map_i,
  output logic [NUM_SEV-1:0]            evt_sts_o,
  output logic                          smi_o,
  output logic                          nmi_o
);
  logic [NUM_SEV-1:0] evt_now;
  logic [NUM_SEV-1:0] evt_prev_q;
  logic [NUM_SEV-1:0] rise;
  logic               smi_d, nmi_d;
  logic               smi_q, nmi_q;

  generate
    for (genvar g = 0; g < NUM_SEV; g++) begin : g_sev
      assign evt_now[g] = (|live_i[g]) & ~evt_msk_i[g];
    end
  endgenerate

  assign rise = evt_now & ~evt_prev_q;

  // Selections of every severity rising this cycle merge into one pulse.
  always_comb begin
    smi_d = 1'b0;
    nmi_d = 1'b0;
    for (int s = 0; s < NUM_SEV; s++) begin
      smi_d |= rise[s] & map_i[s].smi;
      nmi_d |= rise[s] & map_i[s].nmi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev_q <= '0;
      smi_q      <= 1'b0;
      nmi_q      <= 1'b0;
    end else begin
      evt_prev_q <= evt_now;
      smi_q      <= smi_d;
      nmi_q      <= nmi_d;
    end
  end

  assign evt_sts_o = evt_now;
  assign smi_o     = smi_q;
  assign nmi_o     = nmi_q;
endmodule

// File: rtl/gerr_aggregator.sv
module gerr_aggregator
  import gerr_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       err_vld,
  input  logic [SEV_W*N_SRC-1:0] err_sev,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   smi_pulse,
  output logic                   nmi_pulse
);
  localparam int FLAT_W = NUM_SEV * N_SRC;

  logic [NUM_SEV-1:0][N_SRC-1:0] report_v;
  logic [NUM_SEV-1:0][N_SRC-1:0] clr_v;
  logic [NUM_SEV-1:0][N_SRC-1:0] msk_v;
  logic [NUM_SEV-1:0][N_SRC-1:0] sts_v;
  logic [NUM_SEV-1:0][N_SRC-1:0] live_v;
  logic [NUM_SEV-1:0]            evt_sts;
  logic [NUM_SEV-1:0]            evt_msk;
  route_t [NUM_SEV-1:0]          map_v;
  logic [FLAT_W-1:0]             sts_flat;
  logic [FLAT_W-1:0]             msk_flat;

  // Sort each source's report into the severity its code names.
  always_comb begin
    for (int s = 0; s < NUM_SEV; s++) begin
      for (int i = 0; i < N_SRC; i++) begin
        report_v[s][i] = err_vld[i] && (err_sev[SEV_W*i +: SEV_W] == SEV_W'(s));
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SEV; g++) begin : g_bank
      gerr_status_bank #(.N_SRC(N_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .report_i (report_v[g]),
        .clr_i    (clr_v[g]),
        .mask_i   (msk_v[g]),
        .sts_o    (sts_v[g]),
        .live_o   (live_v[g])
      );
    end
  endgenerate

  gerr_regfile #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .rd_i       (reg_rd),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .sts_i      (sts_v),
    .evt_sts_i  (evt_sts),
    .msk_o      (msk_v),
    .clr_o      (clr_v),
    .evt_msk_o  (evt_msk),
    .map_o      (map_v),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  gerr_event_unit #(.N_SRC(N_SRC)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_i    (live_v),
    .evt_msk_i (evt_msk),
    .map_i     (map_v),
    .evt_sts_o (evt_sts),
    .smi_o     (smi_pulse),
    .nmi_o     (nmi_pulse)
  );

  assign sts_flat = sts_v;
  assign msk_flat = msk_v;
endmodule

// File: rtl/gerr_checker.sv
module gerr_checker
  import gerr_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_SRC-1:0]           err_vld,
  input logic [SEV_W*N_SRC-1:0]     err_sev,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [NUM_SEV*N_SRC-1:0]   sts,
  input logic [NUM_SEV*N_SRC-1:0]   msk,
  input logic [NUM_SEV-1:0]         evt_sts,
  input logic                       smi,
  input logic                       nmi
);
  logic [NUM_SEV-1:0][N_SRC-1:0] want_set;
  logic [NUM_SEV-1:0][N_SRC-1:0] want_clr;

  always_comb begin
    for (int s = 0; s < NUM_SEV; s++) begin
      for (int i = 0; i < N_SRC; i++) begin
        want_set[s][i] = err_vld[i] && err_sev[SEV_W*i +: SEV_W] == SEV_W'(s)
                         && !msk[s*N_SRC + i];
        want_clr[s][i] = reg_wr && reg_addr == ADDR_W'(s) && reg_wdata[i];
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SEV; g++) begin : g_sev
      AST_SET_NEEDS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[g*N_SRC +: N_SRC] & ~$past(sts[g*N_SRC +: N_SRC]) & ~$past(want_set[g])) == '0
      ) else $error("unreported or masked bit logged"); // R5
      AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sts[g*N_SRC +: N_SRC]) & ~$past(want_clr[g]) & ~sts[g*N_SRC +: N_SRC]) == '0
      ) else $error("status bit lost without a clear"); // R3
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(want_set[g]) & ~sts[g*N_SRC +: N_SRC]) == '0
      ) else $error("accepted report not logged"); // R4
    end
  endgenerate

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (smi || nmi) |-> (($past(evt_sts) & ~$past(evt_sts, 2)) != '0)
  ) else $error("pulse without rising event"); // R7
  AST_NO_PULSE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_sts) == $past(evt_sts, 2)) |-> (!smi && !nmi)
  ) else $error("pulse while event steady"); // R7
endmodule

bind gerr_aggregator gerr_checker #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_vld   (err_vld),
  .err_sev   (err_sev),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sts       (sts_flat),
  .msk       (msk_flat),
  .evt_sts   (evt_sts),
  .smi       (smi_pulse),
  .nmi       (nmi_pulse)
);

// File: tb/gerr_aggregator_tb.sv
module gerr_aggregator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC  = 6;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [N_SRC-1:0]       err_vld = '0;
  logic [2*N_SRC-1:0]     err_sev = '0;
  logic                   reg_wr = 1'b0;
  logic                   reg_rd = 1'b0;
  logic [ADDR_W-1:0]      reg_addr = '0;
  logic [DATA_W-1:0]      reg_wdata = '0;
  logic                   rd_valid;
  logic [DATA_W-1:0]      rd_data;
  logic                   smi_pulse, nmi_pulse;

  int checks = 0;
  int errors = 0;
  int smi_cnt = 0;
  int nmi_cnt = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gerr_aggregator #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_sev(err_sev),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse)
  );

  // Monitor: pops the scoreboard on each returned read, counts pulse cycles.
  always @(negedge clk) begin
    if (rst_n) begin
      if (smi_pulse) smi_cnt++;
      if (nmi_pulse) nmi_cnt++;
      if (rd_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected read data actual %0h expected none", rd_data);
        end else begin
          logic [DATA_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rd_data !== e) begin
            errors++;
            $display("FAIL %s read actual %0h expected %0h", t, rd_data, e);
          end
        end
      end
    end
  end

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic report(input int src, input logic [1:0] sev);
    @(negedge clk);
    err_vld[src] = 1'b1; err_sev[2*src +: 2] = sev;
    @(negedge clk);
    err_vld = '0;
  endtask

  task automatic chk_pulses(input int es, input int en, input string t);
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (smi_cnt != es || nmi_cnt != en) begin
      errors++;
      $display("FAIL %s pulses actual smi=%0d nmi=%0d expected smi=%0d nmi=%0d",
               t, smi_cnt, nmi_cnt, es, en);
    end
    smi_cnt = 0;
    nmi_cnt = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R9 unused address
    for (int a = 0; a < 9; a++) rd(a, 0, "R1");
    rd(15, 0, "R9");
    chk_pulses(0, 0, "R1");

    // map: fatal->SMI, non-fatal->NMI, correctable->both
    wr(8, 32'h39);
    rd(8, 32'h39, "R7");

    report(2, 2'd0);
    chk_pulses(1, 0, "R7");
    rd(0, 32'h04, "R2");
    rd(6, 32'h1, "R6");
    report(1, 2'd0);
    chk_pulses(0, 0, "R7");
    rd(0, 32'h06, "R2");
    report(4, 2'd3);
    rd(0, 32'h06, "R2");
    rd(1, 0, "R2");
    rd(2, 0, "R2");

    wr(0, 32'h0);
    rd(0, 32'h06, "R3");
    wr(0, 32'h04);
    rd(0, 32'h02, "R3");
    wr(0, 32'h02);
    rd(0, 0, "R3");
    rd(6, 0, "R6");
    chk_pulses(0, 0, "R7");

    report(3, 2'd1);
    chk_pulses(0, 1, "R7");
    rd(1, 32'h08, "R2");

    wr(5, 32'h01);
    report(0, 2'd2);
    rd(2, 0, "R5");
    rd(5, 32'h01, "R5");
    chk_pulses(0, 0, "R5");
    report(1, 2'd2);
    rd(2, 32'h02, "R5");
    chk_pulses(1, 1, "R7");

    // logged-then-masked: event drops, status stays
    wr(4, 32'h08);
    rd(6, 32'h4, "R6");
    rd(1, 32'h08, "R6");
    wr(4, 32'h0);
    chk_pulses(0, 1, "R7");
    wr(1, 32'h08);
    wr(2, 32'h02);
    wr(5, 32'h0);
    rd(6, 0, "R6");
    chk_pulses(0, 0, "R6");

    // event mask forces 0; unmasking produces a rise
    wr(7, 32'h1);
    report(0, 2'd0);
    rd(0, 32'h01, "R6");
    rd(6, 0, "R6");
    chk_pulses(0, 0, "R6");
    wr(7, 32'h0);
    chk_pulses(1, 0, "R7");
    wr(0, 32'h01);
    chk_pulses(0, 0, "R7");

    // set beats clear in the same cycle
    report(5, 2'd0);
    chk_pulses(1, 0, "R7");
    @(negedge clk);
    err_vld[5] = 1'b1; err_sev[10 +: 2] = 2'd0;
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h20;
    @(negedge clk);
    err_vld = '0; reg_wr = 1'b0;
    rd(0, 32'h20, "R4");
    chk_pulses(0, 0, "R4");
    wr(0, 32'h20);
    rd(0, 0, "R3");

    // two severities rise together, both mapped to SMI
    wr(8, 32'h05);
    @(negedge clk);
    err_vld[0] = 1'b1; err_sev[0 +: 2] = 2'd0;
    err_vld[1] = 1'b1; err_sev[2 +: 2] = 2'd1;
    @(negedge clk);
    err_vld = '0;
    chk_pulses(1, 0, "R8");
    rd(0, 32'h01, "R8");
    rd(1, 32'h02, "R8");
    rd(6, 32'h3, "R8");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing reads actual %0d outstanding expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule